// File: doc/BRIEF.md
# Maskable Interrupt Acceptance Gate

This block sits on the CPU side of the interrupt path and decides when a maskable interrupt line is taken. Request pulses on the group lines are latched into a flag register. A pending flag is taken when it is enabled and the CPU is willing to be interrupted. On the cycle of acceptance the block clears the taken line's flag and enable bits, raises the global mask and withdraws the protected-write permission. It then starts the context save and requests the vector fetch.

Qualification has two paths. On the normal path a flag needs its enable bit and a clear global mask. When the device is in real-time emulation and the CPU is halted, a separate debug enable register qualifies the flags and the global mask has no effect. If emulation is on but the CPU is running, the normal path applies. The service routine clears the global mask through its own strobe when it re-enables interrupts. Only one acceptance is in flight at a time. The next one waits until the vector fetch for the current one has been acknowledged.

Top module: `intGate`

## Requirements
- R1: A 1 on `reqLines[i]` at a clock edge makes `flags[i]` read 1 after that edge.
- R2: On the normal path (`rtEmuMode` and `cpuHalted` not both 1), `acceptPulse` is 1 in an idle cycle exactly when some line has its flag and enable bits set and `globalMask` is 0. It is combinational in that cycle.
- R3: At the edge ending an accept cycle, the flag and enable bits of line `acceptIdx` clear, `globalMask` becomes 1 and `protAllow` becomes 0. Acceptance overrides `maskClr`, `protSet` and any software write to those two bits.
- R4: `ctxSaveStart` is 1 for exactly the one cycle after an accept cycle. `vecReq` is 1 from the following cycle until the cycle in which `vecAck` is sampled 1, inclusive.
- R5: With `rtEmuMode` and `cpuHalted` both 1, a line qualifies when its flag bit and its debug enable bit are set, whatever the value of `globalMask`.
- R6: With `rtEmuMode` 1 and `cpuHalted` 0, qualification follows R2. A set `globalMask` blocks acceptance.
- R7: `maskClr` clears `globalMask` and `maskSet` sets it. Clear wins over set. The reset value of `globalMask` is 1.
- R8: When several lines qualify, `acceptIdx` is the lowest-numbered one.
- R9: With `flagWrEn` 1, `flags` takes `flagWrData`, where 1 sets a bit and 0 clears it. A request on the same line in the same cycle leaves the bit at 1.
- R10: From the accept cycle until `vecAck` is seen, no further `acceptPulse` occurs.
- R11: `enWrEn` loads `enables` from `enWrData`. `dbgWrEn` loads the debug enable register. `protClr` clears `protAllow` and `protSet` sets it, with clear winning over set.
- R12: After reset, `flags`, `enables`, the debug enables and `protAllow` are 0, `globalMask` is 1, and no strobe is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqLines | input | NUM_LINES | Request pulses, one per line |
| flagWrEn | input | 1 | Software write strobe for the flag register |
| flagWrData | input | NUM_LINES | Flag write value |
| enWrEn | input | 1 | Write strobe for the enable register |
| enWrData | input | NUM_LINES | Enable write value |
| dbgWrEn | input | 1 | Write strobe for the debug enable register |
| dbgWrData | input | NUM_LINES | Debug enable write value |
| maskSet | input | 1 | Set the global mask |
| maskClr | input | 1 | Clear the global mask (re-enable interrupts) |
| protSet | input | 1 | Grant protected-write permission |
| protClr | input | 1 | Withdraw protected-write permission |
| rtEmuMode | input | 1 | Device is in real-time emulation |
| cpuHalted | input | 1 | CPU is halted |
| vecAck | input | 1 | Vector fetch completed |
| acceptPulse | output | 1 | A line is accepted in this cycle |
| acceptIdx | output | IDX_W | Index of the accepted line |
| ctxSaveStart | output | 1 | Start the context save |
| vecReq | output | 1 | Vector fetch request, held until acknowledged |
| flags | output | NUM_LINES | Flag register |
| enables | output | NUM_LINES | Enable register |
| globalMask | output | 1 | Global interrupt mask |
| protAllow | output | 1 | Protected-write permission |

## Verification
The assertions check the following on every cycle:
- the register updates that follow an accept cycle;
- the accept, save and fetch order, and that only one of the three strobes is active at a time;
- that no acceptance occurs while a response is in flight;
- that a set global mask blocks acceptance on the normal path;
- that requests are latched into the flags.

Some behaviour only the bench scenarios can show, because they are checked against a reference model:
- the choice of the lowest qualified line;
- the debug-halt path ignoring the mask;
- flag writes racing hardware sets;
- the exact length of the fetch wait.

// File: rtl/intGatePkg.sv
package intGatePkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SAVE  = 2'd1,
    ST_FETCH = 2'd2
  } gateState_t;

  typedef struct packed {
    logic takeLine;
    logic raiseMask;
    logic dropProt;
  } gateStrobes_t;
endpackage

// File: rtl/intGateDp.sv
module intGateDp
  import intGatePkg::*;
#(
  parameter int NUM_LINES = 16,
  localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LINES-1:0] reqLines,
  input  logic                 flagWrEn,
  input  logic [NUM_LINES-1:0] flagWrData,
  input  logic                 enWrEn,
  input  logic [NUM_LINES-1:0] enWrData,
  input  logic                 dbgWrEn,
  input  logic [NUM_LINES-1:0] dbgWrData,
  input  logic                 maskSet,
  input  logic                 maskClr,
  input  logic                 protSet,
  input  logic                 protClr,
  input  logic                 rtEmuMode,
  input  logic                 cpuHalted,
  input  gateStrobes_t         strb,
  output logic                 anyQual,
  output logic [IDX_W-1:0]     pickIdx,
  output logic [NUM_LINES-1:0] flags,
  output logic [NUM_LINES-1:0] enables,
  output logic                 globalMask,
  output logic                 protAllow
);
  logic [NUM_LINES-1:0] dbgEnables;
  logic [NUM_LINES-1:0] qualVec;
  logic [NUM_LINES-1:0] takeMask;
  logic                 debugPath;

  assign debugPath = rtEmuMode & cpuHalted;

  always_comb begin
    if (debugPath) qualVec = flags & dbgEnables;
    else if (globalMask) qualVec = '0;
    else qualVec = flags & enables;
  end

  assign anyQual = |qualVec;

  always_comb begin
    pickIdx = '0;
    for (int i = NUM_LINES - 1; i >= 0; i--) begin
      if (qualVec[i]) pickIdx = IDX_W'(i);
    end
  end

  always_comb begin
    takeMask = '0;
    if (strb.takeLine) takeMask[pickIdx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flags      <= '0;
      enables    <= '0;
      dbgEnables <= '0;
      globalMask <= 1'b1;
      protAllow  <= 1'b0;
    end else begin
      flags   <= ((flagWrEn ? flagWrData : flags) & ~takeMask) | reqLines;
      enables <= (enWrEn ? enWrData : enables) & ~takeMask;
      if (dbgWrEn) dbgEnables <= dbgWrData;
      if (strb.raiseMask) globalMask <= 1'b1;
      else if (maskClr) globalMask <= 1'b0;
      else if (maskSet) globalMask <= 1'b1;
      if (strb.dropProt) protAllow <= 1'b0;
      else if (protClr) protAllow <= 1'b0;
      else if (protSet) protAllow <= 1'b1;
    end
  end
endmodule

// File: rtl/intGateCtrl.sv
module intGateCtrl
  import intGatePkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         anyQual,
  input  logic         vecAck,
  output gateStrobes_t strb,
  output logic         acceptPulse,
  output logic         ctxSaveStart,
  output logic         vecReq
);
  gateState_t state, stateNxt;

  assign acceptPulse  = (state == ST_IDLE) && anyQual;
  assign ctxSaveStart = (state == ST_SAVE);
  assign vecReq       = (state == ST_FETCH);

  always_comb begin
    strb.takeLine  = acceptPulse;
    strb.raiseMask = acceptPulse;
    strb.dropProt  = acceptPulse;
  end

  always_comb begin
    stateNxt = state;
    unique case (state)
      ST_IDLE:  if (anyQual) stateNxt = ST_SAVE;
      ST_SAVE:  stateNxt = ST_FETCH;
      ST_FETCH: if (vecAck) stateNxt = ST_IDLE;
      default:  stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else state <= stateNxt;
  end
endmodule

// File: rtl/intGate.sv
module intGate
  import intGatePkg::*;
#(
  parameter int NUM_LINES = 16,
  localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LINES-1:0] reqLines,
  input  logic                 flagWrEn,
  input  logic [NUM_LINES-1:0] flagWrData,
  input  logic                 enWrEn,
  input  logic [NUM_LINES-1:0] enWrData,
  input  logic                 dbgWrEn,
  input  logic [NUM_LINES-1:0] dbgWrData,
  input  logic                 maskSet,
  input  logic                 maskClr,
  input  logic                 protSet,
  input  logic                 protClr,
  input  logic                 rtEmuMode,
  input  logic                 cpuHalted,
  input  logic                 vecAck,
  output logic                 acceptPulse,
  output logic [IDX_W-1:0]     acceptIdx,
  output logic                 ctxSaveStart,
  output logic                 vecReq,
  output logic [NUM_LINES-1:0] flags,
  output logic [NUM_LINES-1:0] enables,
  output logic                 globalMask,
  output logic                 protAllow
);
  gateStrobes_t strb;
  logic         anyQual;

  intGateDp #(.NUM_LINES(NUM_LINES)) dp_i (
    .clk(clk), .rstN(rstN), .reqLines(reqLines),
    .flagWrEn(flagWrEn), .flagWrData(flagWrData),
    .enWrEn(enWrEn), .enWrData(enWrData),
    .dbgWrEn(dbgWrEn), .dbgWrData(dbgWrData),
    .maskSet(maskSet), .maskClr(maskClr),
    .protSet(protSet), .protClr(protClr),
    .rtEmuMode(rtEmuMode), .cpuHalted(cpuHalted),
    .strb(strb), .anyQual(anyQual), .pickIdx(acceptIdx),
    .flags(flags), .enables(enables),
    .globalMask(globalMask), .protAllow(protAllow)
  );

  intGateCtrl ctrl_i (
    .clk(clk), .rstN(rstN), .anyQual(anyQual), .vecAck(vecAck),
    .strb(strb), .acceptPulse(acceptPulse),
    .ctxSaveStart(ctxSaveStart), .vecReq(vecReq)
  );
endmodule

// File: rtl/intGateChk.sv
module intGateChk #(
  parameter int NUM_LINES = 16,
  localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [NUM_LINES-1:0] reqLines,
  input logic                 rtEmuMode,
  input logic                 cpuHalted,
  input logic                 vecAck,
  input logic                 acceptPulse,
  input logic [IDX_W-1:0]     acceptIdx,
  input logic                 ctxSaveStart,
  input logic                 vecReq,
  input logic [NUM_LINES-1:0] flags,
  input logic                 globalMask,
  input logic                 protAllow
);
  AST_REQ_LATCHED: assert property (@(posedge clk) disable iff (!rstN)
    (reqLines != '0) |=> ((flags & $past(reqLines)) == $past(reqLines))); // R1
  AST_PICK_IS_FLAGGED: assert property (@(posedge clk) disable iff (!rstN)
    acceptPulse |-> flags[acceptIdx]); // R2
  AST_MASK_BLOCKS: assert property (@(posedge clk) disable iff (!rstN)
    (!(rtEmuMode && cpuHalted) && globalMask) |-> !acceptPulse); // R2
  AST_ACCEPT_RAISES_MASK: assert property (@(posedge clk) disable iff (!rstN)
    acceptPulse |=> globalMask); // R3
  AST_ACCEPT_DROPS_PROT: assert property (@(posedge clk) disable iff (!rstN)
    acceptPulse |=> !protAllow); // R3
  AST_SAVE_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rstN)
    acceptPulse |=> ctxSaveStart); // R4
  AST_FETCH_AFTER_SAVE: assert property (@(posedge clk) disable iff (!rstN)
    ctxSaveStart |=> vecReq); // R4
  AST_FETCH_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (vecReq && !vecAck) |=> vecReq); // R4
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({acceptPulse, ctxSaveStart, vecReq})); // R10
  AST_NO_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (ctxSaveStart || vecReq) |-> !acceptPulse); // R10
endmodule

bind intGate intGateChk #(.NUM_LINES(NUM_LINES)) chk_i (
  .clk(clk), .rstN(rstN), .reqLines(reqLines),
  .rtEmuMode(rtEmuMode), .cpuHalted(cpuHalted), .vecAck(vecAck),
  .acceptPulse(acceptPulse), .acceptIdx(acceptIdx),
  .ctxSaveStart(ctxSaveStart), .vecReq(vecReq), .flags(flags),
  .globalMask(globalMask), .protAllow(protAllow)
);

// File: tb/intGate_tb_top.sv
`timescale 1ns/1ps
module intGate_tb_top;
  localparam int N = 16;
  localparam int IW = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [N-1:0] reqLines = '0, flagWrData = '0, enWrData = '0, dbgWrData = '0;
  logic flagWrEn = 0, enWrEn = 0, dbgWrEn = 0, maskSet = 0, maskClr = 0;
  logic protSet = 0, protClr = 0, rtEmuMode = 0, cpuHalted = 0, vecAck = 0;
  logic acceptPulse, ctxSaveStart, vecReq, globalMask, protAllow;
  logic [IW-1:0] acceptIdx;
  logic [N-1:0] flags, enables;

  always #10 clk = ~clk;

  intGate #(.NUM_LINES(N)) dut_i (.*);

  int vectors = 0, errors = 0;
  logic [N-1:0] mFlags, mEn, mDbg;
  logic mMask, mProt;
  int mState;

  function automatic logic [N-1:0] qualOf();
    if (rtEmuMode && cpuHalted) return mFlags & mDbg;
    if (mMask) return '0;
    return mFlags & mEn;
  endfunction

  function automatic int lowestOf(logic [N-1:0] v);
    for (int i = 0; i < N; i++) if (v[i]) return i;
    return 0;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic clearInputs();
    reqLines = '0; flagWrEn = 0; enWrEn = 0; dbgWrEn = 0;
    maskSet = 0; maskClr = 0; protSet = 0; protClr = 0; vecAck = 0;
  endtask

  // Inputs already driven after a negedge; check, then advance model at posedge.
  task automatic step();
    logic [N-1:0] q, take;
    logic acc;
    int idx;
    #2;
    q = qualOf();
    acc = (mState == 0) && (q != '0);
    idx = lowestOf(q);
    check("R1/R9 flags", 32'(flags), 32'(mFlags));
    check("R11 enables", 32'(enables), 32'(mEn));
    check("R7 globalMask", 32'(globalMask), 32'(mMask));
    check("R11 protAllow", 32'(protAllow), 32'(mProt));
    check("R2/R5/R6/R10 acceptPulse", 32'(acceptPulse), 32'(acc));
    if (acc) check("R8 acceptIdx", 32'(acceptIdx), 32'(idx));
    check("R4 ctxSaveStart", 32'(ctxSaveStart), 32'(mState == 1));
    check("R4 vecReq", 32'(vecReq), 32'(mState == 2));
    take = acc ? (N'(1) << idx) : '0;
    @(posedge clk);
    mFlags = ((flagWrEn ? flagWrData : mFlags) & ~take) | reqLines;
    mEn = (enWrEn ? enWrData : mEn) & ~take;
    if (dbgWrEn) mDbg = dbgWrData;
    if (acc) mMask = 1; else if (maskClr) mMask = 0; else if (maskSet) mMask = 1;
    if (acc) mProt = 0; else if (protClr) mProt = 0; else if (protSet) mProt = 1;
    case (mState)
      0: if (acc) mState = 1;
      1: mState = 2;
      default: if (vecAck) mState = 0;
    endcase
    @(negedge clk);
    clearInputs();
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    int seed;
    seed = 32'h5eed_1234;
    void'($urandom(seed));
    mFlags = '0; mEn = '0; mDbg = '0; mMask = 1; mProt = 0; mState = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    // R12: reset state
    step();

    // R9: write plus same-cycle hardware set on line 3 stays 1
    flagWrEn = 1; flagWrData = 16'h0024; reqLines = 16'h0008; step();
    flagWrEn = 1; flagWrData = 16'h0000; reqLines = 16'h0008; step();
    // R8: lines 5 and 2 pending and enabled, mask opened -> line 2 first
    flagWrEn = 1; flagWrData = 16'h0024; enWrEn = 1; enWrData = 16'h00ff; protSet = 1; step();
    maskClr = 1; step();
    repeat (4) step();             // R4/R10: fetch pending, no new accept
    vecAck = 1; step();
    maskClr = 1; maskSet = 1; step();  // R7: clear wins
    repeat (4) step();
    vecAck = 1; step();

    // R6: emulation, CPU running, mask set -> blocked
    rtEmuMode = 1; cpuHalted = 0; maskSet = 1; flagWrEn = 1; flagWrData = 16'h0100;
    dbgWrEn = 1; dbgWrData = 16'h0100; step();
    rtEmuMode = 1; cpuHalted = 0; step();
    // R5: halted -> debug path accepts despite mask
    rtEmuMode = 1; cpuHalted = 1; step();
    rtEmuMode = 1; cpuHalted = 1; step();
    rtEmuMode = 1; cpuHalted = 1; vecAck = 1; step();
    rtEmuMode = 1; cpuHalted = 1; vecAck = 1; step();

    // Random traffic
    for (int k = 0; k < 4000; k++) begin
      reqLines   = (($urandom % 4) == 0) ? N'(1 << ($urandom % N)) : '0;
      flagWrEn   = (($urandom % 16) == 0); flagWrData = N'($urandom);
      enWrEn     = (($urandom % 12) == 0); enWrData = N'($urandom);
      dbgWrEn    = (($urandom % 20) == 0); dbgWrData = N'($urandom);
      maskClr    = (($urandom % 6) == 0);
      maskSet    = (($urandom % 10) == 0);
      protSet    = (($urandom % 8) == 0);
      protClr    = (($urandom % 12) == 0);
      rtEmuMode  = (($urandom % 4) == 0);
      cpuHalted  = (($urandom % 2) == 0);
      vecAck     = (($urandom % 3) == 0);
      step();
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule